// File: doc/BRIEF.md
# Accumulator ALU with Decimal Correction

This block is the arithmetic and logic unit of an 8-bit accumulator machine, together with the accumulator and the two status flags it updates: carry (C) and half-carry (HC). Each cycle it takes a 4-bit operation code, an 8-bit operand and a write enable. The operand comes from memory or from immediate data, and fetching it is left to the surrounding logic. When the write enable is high, the new accumulator value and flags are loaded on the rising clock edge. When it is low, the accumulator and both flags hold.

Subtraction uses carry as not-borrow: it computes A + ~operand + C. Decimal correction turns the binary result of a preceding add-with-carry or subtract-with-carry into packed BCD. To choose the adding or the subtracting form of the correction, the block keeps a small state machine with two states:
- MODE_ADD is the reset state. An add-with-carry moves the machine into MODE_ADD.
- MODE_SUB is entered by a subtract-with-carry.

Every other operation, and every cycle without the write enable, leaves the state where it is. Decimal correction then applies the form that matches the current state.

Top module: `acc_alu_core`

## Requirements
- R1: When reset (rst_n low, asynchronous) is asserted, acc_o becomes 0x00, carry_o becomes 0 and half_o becomes 0, and the correction state becomes MODE_ADD.
- R2: While wr_en is 0, acc_o, carry_o, half_o and the correction state keep their values, whatever op_i is.
- R3: ADD (op_i=0) loads A with (A + operand) mod 256 and leaves C and HC unchanged.
- R4: ADC (op_i=1) loads A with (A + operand + C) mod 256, loads C with the carry out of bit 7 and HC with the carry out of bit 3, and moves the correction state to MODE_ADD.
- R5: SUBC (op_i=2) loads A with (A + ~operand + C) mod 256, loads C with the carry out of bit 7 and HC with the carry out of bit 3, and moves the correction state to MODE_SUB.
- R6: AND (op_i=3), OR (op_i=4) and XOR (op_i=5) load A with the bitwise result of A and the operand, and leave C and HC unchanged.
- R7: INC (op_i=6) and DEC (op_i=7) change A by one with wrap-around, and CLR (op_i=8) loads A with 0. All three leave C and HC unchanged.
- R8: RRC (op_i=9) shifts A right by one place, loading old C into bit 7 and old bit 0 into C. HC is unchanged.
- R9: SWAP (op_i=10) exchanges the nibbles A[7:4] and A[3:0] and leaves C and HC unchanged.
- R10: SC (op_i=12) sets C to 1 and RC (op_i=13) clears C to 0. Both leave A and HC unchanged.
- R11: DCOR (op_i=11) in MODE_ADD adds 0x06 when HC=1 or A[3:0]>9, and adds 0x60 when C=1 or A>0x99, with the result taken mod 256.
- R12: DCOR in MODE_SUB subtracts 0x06 when HC=0 and subtracts 0x60 when C=0, with the result taken mod 256. In both states DCOR leaves C, HC and the state unchanged.
- R13: The reserved codes op_i=14 and op_i=15 leave A, C and HC unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Loads result and flags at the clock edge when high |
| op_i | input | 4 | Operation code (see requirements) |
| opnd_i | input | W | Operand from memory or immediate data |
| acc_o | output | W | Accumulator |
| carry_o | output | 1 | Carry flag |
| half_o | output | 1 | Half-carry flag |

## Verification
The bench builds the block with the default width W=8. This width makes the nibble boundary fall at bit 3, so the half-carry and both decimal-correction forms can be exercised with real packed-BCD sums and differences. The stimulus chains ADC and SUBC with DCOR so that the correction state is checked in both states, including a correction issued after a plain ADD that must keep the subtract form. The bench also covers wrap-around of INC and DEC, both rotate directions of the carry, the reserved codes, and a mid-run reset that must bring back the adding form.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    parameter int unsigned DATA_W = 8;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUBB  = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_CLR   = 4'd8,
        OP_RORC  = 4'd9,
        OP_SWAP  = 4'd10,
        OP_DADJ  = 4'd11,
        OP_SETC  = 4'd12,
        OP_CLRC  = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } alu_op_e;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } dec_mode_e;
endpackage

// File: rtl/acc_nib_adder.sv
module acc_nib_adder #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         hco_o
);
    localparam int unsigned NIB = W / 2;

    logic [NIB:0] low_sum;
    logic [W:0]   full_sum;

    assign low_sum  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, ci_i};
    assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};

    assign sum_o = full_sum[W-1:0];
    assign co_o  = full_sum[W];
    assign hco_o = low_sum[NIB];
endmodule

// File: rtl/acc_dec_adjust.sv
module acc_dec_adjust #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    input  logic         hc_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o
);
    localparam int unsigned NIB = W / 2;
    localparam logic [NIB-1:0] NINE = NIB'(9);
    localparam logic [W-1:0] SIX_LO = W'(6);
    localparam logic [W-1:0] SIX_HI = SIX_LO << NIB;

    logic lo_big, hi_big, lo_fix, hi_fix;
    logic [W-1:0] corr;

    assign lo_big = a_i[NIB-1:0] > NINE;
    assign hi_big = (a_i[W-1:NIB] > NINE) || ((a_i[W-1:NIB] == NINE) && lo_big);

    always_comb begin
        if (sub_i) begin
            lo_fix = ~hc_i;
            hi_fix = ~c_i;
        end else begin
            lo_fix = hc_i | lo_big;
            hi_fix = c_i | hi_big;
        end
        corr = (lo_fix ? SIX_LO : '0) | (hi_fix ? SIX_HI : '0);
        y_o  = sub_i ? (a_i - corr) : (a_i + corr);
    end
endmodule

// File: rtl/acc_shuffle.sv
module acc_shuffle #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    output logic [W-1:0] rot_o,
    output logic         rot_c_o,
    output logic [W-1:0] swp_o
);
    localparam int unsigned NIB = W / 2;

    assign rot_o   = {c_i, a_i[W-1:1]};
    assign rot_c_o = a_i[0];

    for (genvar g = 0; g < NIB; g++) begin : g_swap
        assign swp_o[g]       = a_i[g + NIB];
        assign swp_o[g + NIB] = a_i[g];
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] acc_o,
    output logic         carry_o,
    output logic         half_o
);
    localparam int unsigned NIB = W / 2;
    localparam logic [W-1:0] ONE_W = W'(1);

    alu_op_e   op;
    dec_mode_e mode_q, mode_d;

    logic [W-1:0] acc_q, acc_d;
    logic         c_q, c_d, hc_q, hc_d;

    logic [W-1:0] add_b, add_sum, dadj_y, rot_y, swp_y;
    logic         add_ci, add_co, add_hco, rot_c;

    assign op = alu_op_e'(op_i);

    // shared adder: plain add, add with carry, subtract as add of complement
    always_comb begin
        add_b  = (op == OP_SUBB) ? ~opnd_i : opnd_i;
        add_ci = (op == OP_ADD) ? 1'b0 : c_q;
    end

    acc_nib_adder #(.W(W)) u_adder (
        .a_i   (acc_q),
        .b_i   (add_b),
        .ci_i  (add_ci),
        .sum_o (add_sum),
        .co_o  (add_co),
        .hco_o (add_hco)
    );

    acc_dec_adjust #(.W(W)) u_dadj (
        .a_i   (acc_q),
        .c_i   (c_q),
        .hc_i  (hc_q),
        .sub_i (mode_q == MODE_SUB),
        .y_o   (dadj_y)
    );

    acc_shuffle #(.W(W)) u_shuf (
        .a_i     (acc_q),
        .c_i     (c_q),
        .rot_o   (rot_y),
        .rot_c_o (rot_c),
        .swp_o   (swp_y)
    );

    // next correction state
    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            unique case (op)
                OP_ADDC: mode_d = MODE_ADD;
                OP_SUBB: mode_d = MODE_SUB;
                default: mode_d = mode_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_ADD;
        else        mode_q <= mode_d;
    end

    // result and flag selection
    always_comb begin
        acc_d = acc_q;
        c_d   = c_q;
        hc_d  = hc_q;
        unique case (op)
            OP_ADD:  acc_d = add_sum;
            OP_ADDC, OP_SUBB: begin
                acc_d = add_sum;
                c_d   = add_co;
                hc_d  = add_hco;
            end
            OP_AND:  acc_d = acc_q & opnd_i;
            OP_OR:   acc_d = acc_q | opnd_i;
            OP_XOR:  acc_d = acc_q ^ opnd_i;
            OP_INC:  acc_d = acc_q + ONE_W;
            OP_DEC:  acc_d = acc_q - ONE_W;
            OP_CLR:  acc_d = '0;
            OP_RORC: begin
                acc_d = rot_y;
                c_d   = rot_c;
            end
            OP_SWAP: acc_d = swp_y;
            OP_DADJ: acc_d = dadj_y;
            OP_SETC: c_d = 1'b1;
            OP_CLRC: c_d = 1'b0;
            OP_RSV14, OP_RSV15: acc_d = acc_q;
            default: acc_d = acc_q;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            c_q   <= 1'b0;
            hc_q  <= 1'b0;
        end else if (wr_en) begin
            acc_q <= acc_d;
            c_q   <= c_d;
            hc_q  <= hc_d;
        end
    end

    assign acc_o   = acc_q;
    assign carry_o = c_q;
    assign half_o  = hc_q;

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(acc_q) && $stable(c_q) && $stable(hc_q) && $stable(mode_q)); // R2
    AST_ADD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_ADD) |=> $stable(c_q) && $stable(hc_q)); // R3
    AST_ADDC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_ADDC) |=> mode_q == MODE_ADD); // R4
    AST_SUBB_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SUBB) |=> mode_q == MODE_SUB); // R5
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_CLR) |=> acc_q == '0); // R7
    AST_RORC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_RORC) |=> c_q == $past(acc_q[0]) && acc_q[W-1] == $past(c_q)); // R8
    AST_SWAP_NIBBLES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SWAP) |=> acc_q == {$past(acc_q[NIB-1:0]), $past(acc_q[W-1:NIB])}); // R9
    AST_SETC_CLRC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (op == OP_SETC || op == OP_CLRC)) |=> c_q == (op_i == 4'd12 ? $past(op == OP_SETC) : $past(op == OP_SETC)) && $stable(acc_q)); // R10
    AST_DADJ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_DADJ) |=> $stable(c_q) && $stable(hc_q) && $stable(mode_q)); // R12
    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (op == OP_RSV14 || op == OP_RSV15)) |=> $stable(acc_q) && $stable(c_q) && $stable(hc_q)); // R13
endmodule

// File: tb/acc_alu_core_tb_top.sv
module acc_alu_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 33;

    // {op, operand, expected acc, expected C, expected HC}
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd0,  8'h45, 8'h45, 1'b0, 1'b0},
        {4'd1,  8'h38, 8'h7D, 1'b0, 1'b0},
        {4'd11, 8'h00, 8'h83, 1'b0, 1'b0},
        {4'd12, 8'h00, 8'h83, 1'b1, 1'b0},
        {4'd2,  8'h38, 8'h4B, 1'b1, 1'b0},
        {4'd11, 8'h00, 8'h45, 1'b1, 1'b0},
        {4'd1,  8'h99, 8'hDF, 1'b0, 1'b0},
        {4'd11, 8'h00, 8'h45, 1'b0, 1'b0},
        {4'd1,  8'h0B, 8'h50, 1'b0, 1'b1},
        {4'd11, 8'h00, 8'h56, 1'b0, 1'b1},
        {4'd1,  8'hC0, 8'h16, 1'b1, 1'b0},
        {4'd3,  8'h0F, 8'h06, 1'b1, 1'b0},
        {4'd4,  8'hA0, 8'hA6, 1'b1, 1'b0},
        {4'd5,  8'hFF, 8'h59, 1'b1, 1'b0},
        {4'd9,  8'h00, 8'hAC, 1'b1, 1'b0},
        {4'd9,  8'h00, 8'hD6, 1'b0, 1'b0},
        {4'd10, 8'h00, 8'h6D, 1'b0, 1'b0},
        {4'd6,  8'h00, 8'h6E, 1'b0, 1'b0},
        {4'd7,  8'h00, 8'h6D, 1'b0, 1'b0},
        {4'd8,  8'h33, 8'h00, 1'b0, 1'b0},
        {4'd7,  8'h00, 8'hFF, 1'b0, 1'b0},
        {4'd6,  8'h00, 8'h00, 1'b0, 1'b0},
        {4'd12, 8'h00, 8'h00, 1'b1, 1'b0},
        {4'd13, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'd2,  8'h01, 8'hFE, 1'b0, 1'b0},
        {4'd11, 8'h00, 8'h98, 1'b0, 1'b0},
        {4'd14, 8'h55, 8'h98, 1'b0, 1'b0},
        {4'd15, 8'hAA, 8'h98, 1'b0, 1'b0},
        {4'd12, 8'h00, 8'h98, 1'b1, 1'b0},
        {4'd2,  8'h12, 8'h86, 1'b1, 1'b1},
        {4'd11, 8'h00, 8'h86, 1'b1, 1'b1},
        {4'd0,  8'h01, 8'h87, 1'b1, 1'b1},
        {4'd11, 8'h00, 8'h87, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] op;
    logic [7:0] opnd;
    logic [7:0] acc;
    logic       cy, hc;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_alu_core #(.W(8)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .op_i    (op),
        .opnd_i  (opnd),
        .acc_o   (acc),
        .carry_o (cy),
        .half_o  (hc)
    );

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'd0:               return "R3";
            4'd1:               return "R4";
            4'd2:               return "R5";
            4'd3, 4'd4, 4'd5:   return "R6";
            4'd6, 4'd7, 4'd8:   return "R7";
            4'd9:               return "R8";
            4'd10:              return "R9";
            4'd11:              return "R11/R12";
            4'd12, 4'd13:       return "R10";
            default:            return "R13";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] ea, input logic ec, input logic eh);
        checks++;
        if (acc !== ea || cy !== ec || hc !== eh) begin
            errors++;
            $display("FAIL %s: acc=%h c=%b hc=%b expected acc=%h c=%b hc=%b",
                     req, acc, cy, hc, ea, ec, eh);
        end
    endtask

    // inputs are set at a falling edge; result sampled at the next falling edge
    task automatic step(input logic we, input logic [3:0] code, input logic [7:0] val);
        wr_en = we;
        op    = code;
        opnd  = val;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0;
        op    = 4'd0;
        opnd  = 8'h00;
        repeat (2) @(negedge clk);
        check("R1", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            step(1'b1, VEC[i][21:18], VEC[i][17:10]);
            check(req_of(VEC[i][21:18]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R2: no write, state must hold at 87 / C=1 / HC=1
        step(1'b0, 4'd8, 8'h00);
        check("R2", 8'h87, 1'b1, 1'b1);
        step(1'b0, 4'd13, 8'h00);
        check("R2", 8'h87, 1'b1, 1'b1);
        // R2: state unchanged -> still MODE_SUB, so DCOR with C=1 HC=1 leaves 87
        step(1'b0, 4'd1, 8'h00);
        step(1'b1, 4'd11, 8'h00);
        check("R2", 8'h87, 1'b1, 1'b1);

        // R1: mid-run reset
        wr_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset restores MODE_ADD (add 0x0A, then correction gives 0x10, not 0xA4)
        step(1'b1, 4'd0, 8'h0A);
        check("R3", 8'h0A, 1'b0, 1'b0);
        step(1'b1, 4'd11, 8'h00);
        check("R1", 8'h10, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule